// File: doc/BRIEF.md
# Memory Controller Configuration Register File

This block holds the programmable settings of an external memory controller that drives several chip selects. A processor reaches it over a plain 32-bit word bus (address, write enable, write data, read data). Inside are a general control word, a mask for the base-address compare, a read-only copy of the power-on strap word, and a configuration and timing word for every chip select. All configuration and timing words, the control word and the mask leave the block as parallel outputs for the address decoder and the memory sequencers.

Chip select 0 must work before any software runs. While reset is held, the block captures the strap word and uses it to build chip select 0's configuration: the memory type, the bus width and the enable bit. It also loads a default timing word chosen by that memory type. Every other register clears to zero.

Reads are combinational from the address. Writes take effect at the clock edge. A write to the strap copy changes nothing and produces a one-cycle warning pulse.

Top module: `mc_cfg_regs`

## Requirements
- R1: While `rst` is high at a clock edge, the control word, the mask and all configuration and timing words of chip selects 1 to 7 become zero, and the strap copy (offset 0x04) takes the value of `boot_cfg`.
- R2: After reset, chip select 0's configuration word is zero except enable bit 0 = 1, memory type in bits [3:1] = {0, boot_cfg[3:2]} and bus width in bits [5:4] = boot_cfg[1:0].
- R3: After reset, chip select 0's timing word depends on boot_cfg[3:2]: 0 (SDRAM) gives 0x0F000413, 1 (synchronous burst SRAM) gives 0x00000202, 2 (asynchronous) gives 0x03FFFFFF, and 3 (synchronous) gives 0x00000101.
- R4: The control word at offset 0x00 is read/write. It keeps its value unless it is written, and it drives `ctrl_o`.
- R5: A write to the mask at offset 0x08 stores only `wdata & 0x000000FF`. The stored value reads back and drives `mask_o`.
- R6: A write to offset 0x04 leaves the strap copy unchanged. `ro_warn` is high for exactly the one cycle that follows each such write edge.
- R7: Chip select k (0 to 7) has its configuration word at 0x10 + 8k and its timing word at 0x14 + 8k, so address bit 2 selects timing. The words read back and drive `cs_cfg[32k +: 32]` and `cs_tim[32k +: 32]`.
- R8: A read at an undefined offset (0x0C, or 0x50 and above) returns zero. A write there changes no register.
- R9: `rdata` shows the addressed register in the same cycle. A value written at an edge appears from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap word is sampled while high |
| boot_cfg | input | 32 | Power-on strap word |
| addr | input | 8 | Byte address of the register |
| we | input | 1 | Write enable |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| ro_warn | output | 1 | One-cycle pulse after a write to the strap copy |
| ctrl_o | output | 32 | Control word |
| mask_o | output | 32 | Base-address compare mask |
| cs_cfg | output | 256 | Configuration words, chip select k at [32k +: 32] |
| cs_tim | output | 256 | Timing words, chip select k at [32k +: 32] |

## Verification
Two functions can share one cycle: a bus write and a combinational read of the same register. The bench holds a write to the control word, and separately to the strap copy, with `we` high and checks `rdata` at mid-cycle. It must still show the old value. After the edge, the control word must show the new value, the strap copy must still show its old value, and the warning pulse must be high for just that one cycle. Each reset seed is checked once for every one of the four strap memory types.

// File: rtl/mc_cfg_regs.sv
module mc_cfg_regs #(
  parameter int          NCS       = 8,
  parameter int          AW        = 8,
  parameter int          PAIR_BASE = 16,
  parameter logic [31:0] MASK_OK   = 32'h0000_00FF,
  parameter logic [31:0] T_SDRAM   = 32'h0F00_0413,
  parameter logic [31:0] T_SSRAM   = 32'h0000_0202,
  parameter logic [31:0] T_ASYNC   = 32'h03FF_FFFF,
  parameter logic [31:0] T_SYNC    = 32'h0000_0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       boot_cfg,
  input  logic [AW-1:0]     addr,
  input  logic              we,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              ro_warn,
  output logic [31:0]       ctrl_o,
  output logic [31:0]       mask_o,
  output logic [NCS*32-1:0] cs_cfg,
  output logic [NCS*32-1:0] cs_tim
);
  localparam int SW       = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int PAIR_END = PAIR_BASE + 8 * NCS;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_BOOT = AW'(4);
  localparam logic [AW-1:0] A_MASK = AW'(8);

  logic [31:0] ctrl_q, mask_q, boot_q;
  logic [31:0] cfg_q [NCS];
  logic [31:0] tim_q [NCS];

  logic [AW-1:0] off;
  logic [SW-1:0] slot;
  logic          in_pair, any_hit;
  logic [31:0]   seed_cfg, seed_tim;

  assign off     = addr - AW'(PAIR_BASE);
  assign slot    = off[SW+2:3];
  assign in_pair = (32'(addr) >= PAIR_BASE) && (32'(addr) < PAIR_END);
  assign any_hit = in_pair || addr == A_CTRL || addr == A_BOOT || addr == A_MASK;

  assign seed_cfg = {26'd0, boot_cfg[1:0], 1'b0, boot_cfg[3:2], 1'b1};
  always_comb begin
    case (boot_cfg[3:2])
      2'd0:    seed_tim = T_SDRAM;
      2'd1:    seed_tim = T_SSRAM;
      2'd2:    seed_tim = T_ASYNC;
      default: seed_tim = T_SYNC;
    endcase
  end

  always_ff @(posedge clk) begin
    ro_warn <= 1'b0;
    if (rst) begin
      ctrl_q <= '0;
      mask_q <= '0;
      boot_q <= boot_cfg;
      for (int i = 0; i < NCS; i++) begin
        cfg_q[i] <= '0;
        tim_q[i] <= '0;
      end
      cfg_q[0] <= seed_cfg;
      tim_q[0] <= seed_tim;
    end else if (we) begin
      if (addr == A_CTRL) ctrl_q <= wdata;
      if (addr == A_MASK) mask_q <= wdata & MASK_OK;
      if (addr == A_BOOT) ro_warn <= 1'b1;
      if (in_pair) begin
        if (addr[2]) tim_q[slot] <= wdata;
        else         cfg_q[slot] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)      rdata = ctrl_q;
    else if (addr == A_BOOT) rdata = boot_q;
    else if (addr == A_MASK) rdata = mask_q;
    else if (in_pair)        rdata = addr[2] ? tim_q[slot] : cfg_q[slot];
  end

  assign ctrl_o = ctrl_q;
  assign mask_o = mask_q;
  for (genvar k = 0; k < NCS; k++) begin : g_out
    assign cs_cfg[32*k +: 32] = cfg_q[k];
    assign cs_tim[32*k +: 32] = tim_q[k];
  end

  AST_BOOT_FROZEN: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> $stable(boot_q)); // R6
  AST_WARN_CAUSE: assert property (@(posedge clk) disable iff (rst) ro_warn |-> $past(we) && $past(addr) == A_BOOT); // R6
  AST_MASK_STORE: assert property (@(posedge clk) disable iff (rst) (we && addr == A_MASK) |=> mask_o == ($past(wdata) & MASK_OK)); // R5
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst) !(we && addr == A_CTRL) |=> $stable(ctrl_o)); // R4
  AST_OOR_WRITE: assert property (@(posedge clk) disable iff (rst) (we && !any_hit) |=> $stable(ctrl_o) && $stable(mask_o) && $stable(cs_cfg) && $stable(cs_tim)); // R8
  AST_CS0_ENABLED: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> cs_cfg[0]); // R2
endmodule

// File: tb/tb_mc_cfg_regs.sv
module tb_mc_cfg_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] boot_cfg = 32'h0000_000A;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ro_warn;
  logic [31:0] ctrl_o, mask_o;
  logic [255:0] cs_cfg, cs_tim;

  mc_cfg_regs dut (.clk(clk), .rst(rst), .boot_cfg(boot_cfg), .addr(addr), .we(we),
    .wdata(wdata), .rdata(rdata), .ro_warn(ro_warn), .ctrl_o(ctrl_o), .mask_o(mask_o),
    .cs_cfg(cs_cfg), .cs_tim(cs_tim));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] q_exp [$];
  string       q_tag [$];
  logic        rd_pend = 1'b0;

  function automatic logic [31:0] t_default(input logic [1:0] t);
    case (t)
      2'd0: return 32'h0F00_0413;
      2'd1: return 32'h0000_0202;
      2'd2: return 32'h03FF_FFFF;
      default: return 32'h0000_0101;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    addr = a; we = 1'b0;
    q_exp.push_back(e); q_tag.push_back(tag);
    rd_pend = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; we = 1'b1; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rd_pend) begin
      check(q_tag.pop_front(), rdata, q_exp.pop_front());
      rd_pend = 1'b0;
    end
  end

  task automatic do_reset(input logic [31:0] b);
    @(posedge clk); #1;
    boot_cfg = b; rst = 1'b1; we = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    boot_cfg = 32'h5555_5550;
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset(32'h0000_000A);
    @(negedge clk);
    check("R1 ctrl after reset", ctrl_o, 32'h0);
    check("R1 mask after reset", mask_o, 32'h0);
    check("R1 warn after reset", {31'd0, ro_warn}, 32'h0);
    check("R1 cs1-7 cfg after reset", cs_cfg[255:32] == '0 ? 32'h0 : 32'h1, 32'h0);
    rd(8'h04, 32'h0000_000A, "R1 strap copy");
    rd(8'h10, 32'h0000_0025, "R2 cs0 cfg async x2");
    rd(8'h14, 32'h03FF_FFFF, "R3 cs0 tim async");

    wr(8'h00, 32'hDEAD_BEEF);
    rd(8'h00, 32'hDEAD_BEEF, "R4 ctrl readback");
    check("R4 ctrl_o", ctrl_o, 32'hDEAD_BEEF);
    wr(8'h08, 32'hFFFF_1234);
    rd(8'h08, 32'h0000_0034, "R5 mask masked");
    check("R5 mask_o", mask_o, 32'h0000_0034);

    wr(8'h28, 32'h00AB_0003);
    wr(8'h2C, 32'h1234_5678);
    rd(8'h28, 32'h00AB_0003, "R7 cs3 cfg");
    rd(8'h2C, 32'h1234_5678, "R7 cs3 tim");
    check("R7 cs_cfg[3]", cs_cfg[96 +: 32], 32'h00AB_0003);
    check("R7 cs_tim[3]", cs_tim[96 +: 32], 32'h1234_5678);
    wr(8'h4C, 32'hCAFE_0007);
    rd(8'h4C, 32'hCAFE_0007, "R7 cs7 tim");
    rd(8'h48, 32'h0, "R7 cs7 cfg untouched");
    check("R7 cs_tim[7]", cs_tim[224 +: 32], 32'hCAFE_0007);

    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h50, 32'h0, "R8 read 0x50");
    rd(8'h0C, 32'h0, "R8 read 0x0C");
    rd(8'hFC, 32'h0, "R8 read 0xFC");
    check("R8 ctrl unchanged", ctrl_o, 32'hDEAD_BEEF);
    check("R8 mask unchanged", mask_o, 32'h0000_0034);
    check("R8 cs7 cfg unchanged", cs_cfg[224 +: 32], 32'h0);

    @(posedge clk); #1;
    addr = 8'h04; we = 1'b1; wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R9 strap read during write", rdata, 32'h0000_000A);
    check("R6 no warn before edge", {31'd0, ro_warn}, 32'h0);
    @(posedge clk); #1;
    we = 1'b0;
    @(negedge clk);
    check("R6 warn pulse", {31'd0, ro_warn}, 32'h1);
    check("R6 strap unchanged", rdata, 32'h0000_000A);
    @(negedge clk);
    check("R6 warn ends", {31'd0, ro_warn}, 32'h0);

    @(posedge clk); #1;
    addr = 8'h00; we = 1'b1; wdata = 32'h0000_1111;
    @(negedge clk);
    check("R9 old ctrl before edge", rdata, 32'hDEAD_BEEF);
    @(posedge clk); #1;
    we = 1'b0;
    @(negedge clk);
    check("R9 new ctrl after edge", rdata, 32'h0000_1111);

    for (int t = 0; t < 4; t++) begin
      logic [31:0] b;
      b = 32'hAB00_0000 | (32'(t) << 2) | 32'(3 - t);
      do_reset(b);
      rd(8'h04, b, "R1 strap copy per type");
      rd(8'h10, 32'h1 | (32'(t) << 1) | (32'(3 - t) << 4), "R2 cs0 cfg per type");
      rd(8'h14, t_default(2'(t)), "R3 cs0 tim per type");
      rd(8'h2C, 32'h0, "R1 cs3 tim cleared");
      rd(8'h00, 32'h0, "R1 ctrl cleared");
    end

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule